// File: doc/BRIEF.md
# Two-Channel Card Control Register with LED Blinking

This block holds the control byte of a two-channel interface card and drives the per-channel outputs that come from it. A host reaches it over an 8-bit register bus with an address, a write strobe with write data, and a read strobe with read data. One byte sets three things at once: the oscillator selection for the channel controllers, an active-high reset for each channel, and a 2-bit display mode for each channel's LED.

The LED of a channel can be lit steadily, blink fast, blink slowly or stay dark. The blinking comes from one free-running prescaler inside the block, so all channels in the same blink mode change together. Two read-only firmware version bytes let software confirm that the card is still present. A status location reads as idle, because the serial memory engine that would drive it lies outside this block.

Each channel reset output follows its control bit with no timer of its own. Software is expected to keep a reset bit set for at least 2 ms before clearing it, and the block holds the reset exactly as long as the bit stays set.

Top module: `card_ctrl_regs`

## Requirements
- R1: After a synchronous reset the control byte is 0xFC, so osc_sel is 00, chan_rst is 11, both LEDs are dark (led_out = 00) and bus_rdata is 0x00.
- R2: A write strobe at offset 0x00 stores bus_wdata in the control byte at the next clock edge, and all outputs derived from it change at that edge. A read strobe at offset 0x00 returns exactly the stored byte on bus_rdata after the next clock edge.
- R3: osc_sel equals control bits [1:0]: 00 selects 16 MHz, 01 selects 10 MHz, 10 selects 21 MHz and 11 selects 8 MHz.
- R4: chan_rst[c] equals control bit 2+c for c = 0 and 1, and it stays high for as long as that bit stays set.
- R5: The LED mode of channel c sits in control bits [2c+5:2c+4]. Mode 00 drives led_out[c] to 1 (steady on) and mode 11 drives it to 0 (dark).
- R6: Mode 01 (fast blink) makes led_out[c] toggle every FAST_DIV clock cycles.
- R7: Mode 10 (slow blink) makes led_out[c] toggle every SLOW_DIV clock cycles.
- R8: Both channels in the same blink mode show identical LED levels on every cycle.
- R9: A read at offset 0x10 returns FW_MAJOR and a read at 0x12 returns FW_MINOR. Writes to these offsets change neither byte.
- R10: Reads at the status offset 0x02 and at every unmapped offset return 0x00, and writes to any offset other than 0x00 leave the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register offset within the common area |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid after the edge that samples bus_rd |
| osc_sel | output | 2 | Oscillator selection for the channel controllers |
| chan_rst | output | 2 | Per-channel reset, active high |
| led_out | output | 2 | Per-channel LED drive, 1 = lit |

## Verification
A corrupted control byte shows up on osc_sel, chan_rst or led_out at the edge right after the write that should have set it, and on bus_rdata one cycle after the next read strobe. A read decode fault appears as a wrong byte on the first read of the affected offset. A prescaler fault shows only as a wrong toggle interval or as channels out of phase. Detecting it takes at least two full half-periods of the blink, so the bench watches several periods of each blink rate.

// File: rtl/card_ctrl_pkg.sv
// Shared constants and types for the card control register block.
// Assumes a two-channel card with the channel fields packed in one byte.
package card_ctrl_pkg;

    // LED display modes, 2 bits per channel
    typedef enum logic [1:0] {
        LED_STEADY = 2'b00,
        LED_FAST   = 2'b01,
        LED_SLOW   = 2'b10,
        LED_DARK   = 2'b11
    } led_mode_e;

    localparam int NUM_CHAN = 2;
    localparam int CLK_SEL_W = 2;
    localparam int RST_LSB = CLK_SEL_W;
    localparam int LED_LSB = RST_LSB + NUM_CHAN;
    localparam int LED_W = 2;

    // Register offsets within the common area
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_STAT  = 'h02;
    localparam int OFF_FWMAJ = 'h10;
    localparam int OFF_FWMIN = 'h12;

    // Power-up control value: 16 MHz, both resets, both LEDs dark
    localparam logic [7:0] CTRL_INIT = 8'hFC;
    // Status reads idle: no serial engine sits behind this block
    localparam logic [7:0] STAT_IDLE = 8'h00;

endpackage

// File: rtl/card_blink_prescaler.sv
// Free-running prescaler shared by all channels. It produces one square
// phase per blink rate. Stage 0 toggles every FAST_DIV clocks and stage 1
// every SLOW_DIV clocks. Both divisors are assumed to be at least 1.
module card_blink_prescaler #(
    parameter int FAST_DIV = 2_000_000,
    parameter int SLOW_DIV = 8_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] blink_ph
);

    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW = $clog2(MAX_DIV + 1) + 1;
    localparam int NSTAGE = 2;
    localparam int DIVS [NSTAGE] = '{FAST_DIV, SLOW_DIV};

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam int D = DIVS[g];
        logic [CW-1:0] cnt;
        logic          ph;

        // Count D clocks, then invert this stage's phase
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt <= '0;
                ph  <= 1'b0;
            end else if (cnt == CW'(D - 1)) begin
                cnt <= '0;
                ph  <= ~ph;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        assign blink_ph[g] = ph;
    end

endmodule

// File: rtl/card_led_drive.sv
// Per-channel LED decode: turns each 2-bit mode into a lit/dark level using
// the shared blink phases, so channels in the same mode stay in phase.
module card_led_drive
    import card_ctrl_pkg::*;
(
    input  logic [NUM_CHAN-1:0][LED_W-1:0] led_mode,
    input  logic [1:0]                     blink_ph,
    output logic [NUM_CHAN-1:0]            led_out
);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        // Choose steady, fast phase, slow phase or dark for this channel
        always_comb begin
            unique case (led_mode_e'(led_mode[c]))
                LED_STEADY: led_out[c] = 1'b1;
                LED_FAST:   led_out[c] = blink_ph[0];
                LED_SLOW:   led_out[c] = blink_ph[1];
                default:    led_out[c] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/card_ctrl_regfile.sv
// Host-facing register file: the writable control byte, the read-only
// firmware bytes and an idle status byte. Reads are registered: data
// appears after the edge that samples the read strobe and holds until
// the next read. Unmapped offsets read as zero.
module card_ctrl_regfile
    import card_ctrl_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] FW_MAJOR = 8'h01,
    parameter logic [7:0] FW_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        ctrl_q
);

    logic sel_ctrl, sel_stat, sel_fwmaj, sel_fwmin;
    logic [7:0] rd_mux;

    // Offset decode
    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
        sel_stat  = (bus_addr == ADDR_W'(OFF_STAT));
        sel_fwmaj = (bus_addr == ADDR_W'(OFF_FWMAJ));
        sel_fwmin = (bus_addr == ADDR_W'(OFF_FWMIN));
    end

    // Control byte: only offset 0 is writable
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_INIT;
        else if (bus_wr && sel_ctrl)
            ctrl_q <= bus_wdata;
    end

    // Read data selection
    always_comb begin
        if (sel_ctrl)
            rd_mux = ctrl_q;
        else if (sel_stat)
            rd_mux = STAT_IDLE;
        else if (sel_fwmaj)
            rd_mux = FW_MAJOR;
        else if (sel_fwmin)
            rd_mux = FW_MINOR;
        else
            rd_mux = 8'h00;
    end

    // Read data register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

endmodule

// File: rtl/card_ctrl_regs.sv
// Top of the card control block. It splits the control byte into the
// oscillator selection, the channel resets and the LED modes, and drives
// the LEDs from a shared blink prescaler. The channel resets have no
// timing of their own: software owns the minimum reset time.
module card_ctrl_regs
    import card_ctrl_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter int         FAST_DIV = 2_000_000,
    parameter int         SLOW_DIV = 8_000_000,
    parameter logic [7:0] FW_MAJOR = 8'h01,
    parameter logic [7:0] FW_MINOR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        osc_sel,
    output logic [1:0]        chan_rst,
    output logic [1:0]        led_out
);

    logic [7:0]                     ctrl_q;
    logic [1:0]                     blink_ph;
    logic [NUM_CHAN-1:0][LED_W-1:0] led_mode;

    card_ctrl_regfile #(
        .ADDR_W  (ADDR_W),
        .FW_MAJOR(FW_MAJOR),
        .FW_MINOR(FW_MINOR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .ctrl_q   (ctrl_q)
    );

    card_blink_prescaler #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .blink_ph(blink_ph)
    );

    // Field split of the control byte
    assign osc_sel  = ctrl_q[CLK_SEL_W-1:0];
    assign chan_rst = ctrl_q[RST_LSB +: NUM_CHAN];
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_mode
        assign led_mode[c] = ctrl_q[LED_LSB + LED_W*c +: LED_W];
    end

    card_led_drive u_led (
        .led_mode(led_mode),
        .blink_ph(blink_ph),
        .led_out (led_out)
    );

endmodule

// File: rtl/card_ctrl_regs_chk.sv
// Port-level checker for card_ctrl_regs, attached with bind below.
module card_ctrl_regs_chk #(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] FW_MAJOR = 8'h01,
    parameter logic [7:0] FW_MINOR = 8'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic [1:0]        osc_sel,
    input logic [1:0]        chan_rst,
    input logic [1:0]        led_out
);

    logic wr_ctrl;
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(0));

    p_osc_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> osc_sel == $past(bus_wdata[1:0]));

    p_rst_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> chan_rst == $past(bus_wdata[3:2]));

    p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(osc_sel) && $stable(chan_rst));

    p_led0_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[5:4] == 2'b00) |=> led_out[0]);

    p_led1_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[7:6] == 2'b11) |=> !led_out[1]);

    p_fw_major_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h10)) |=> bus_rdata == FW_MAJOR);

    p_fw_minor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h12)) |=> bus_rdata == FW_MINOR);

    p_stat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h02)) |=> bus_rdata == 8'h00);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind card_ctrl_regs card_ctrl_regs_chk #(
    .ADDR_W  (ADDR_W),
    .FW_MAJOR(FW_MAJOR),
    .FW_MINOR(FW_MINOR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .osc_sel  (osc_sel),
    .chan_rst (chan_rst),
    .led_out  (led_out)
);

// File: tb/sim_card_ctrl_regs.sv
// Self-checking bench for card_ctrl_regs: a vector table walked by one
// loop, then directed tests for reset, read decode and blink timing.
module sim_card_ctrl_regs;

    localparam int         AW    = 6;
    localparam int         FDIV  = 3;
    localparam int         SDIV  = 7;
    localparam logic [7:0] FWMAJ = 8'h2A;
    localparam logic [7:0] FWMIN = 8'h07;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic [1:0]    osc_sel, chan_rst, led_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    card_ctrl_regs #(
        .ADDR_W(AW), .FAST_DIV(FDIV), .SLOW_DIV(SDIV),
        .FW_MAJOR(FWMAJ), .FW_MINOR(FWMIN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .osc_sel(osc_sel), .chan_rst(chan_rst), .led_out(led_out)
    );

    // {wdata, expected osc_sel, expected chan_rst, expected led_out}
    localparam int NV = 9;
    localparam logic [13:0] VECS [NV] = '{
        {8'hFC, 2'd0, 2'b11, 2'b00},
        {8'h00, 2'd0, 2'b00, 2'b11},
        {8'h01, 2'd1, 2'b00, 2'b11},
        {8'h02, 2'd2, 2'b00, 2'b11},
        {8'h03, 2'd3, 2'b00, 2'b11},
        {8'h04, 2'd0, 2'b01, 2'b11},
        {8'h08, 2'd0, 2'b10, 2'b11},
        {8'h3C, 2'd0, 2'b11, 2'b10},
        {8'hCF, 2'd3, 2'b11, 2'b01}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Check that every full toggle interval of one LED equals div
    task automatic measure_blink(input int ch, input int div, input string req);
        logic prev;
        int last = -1;
        int n_tr = 0;
        int bad = 0;
        prev = led_out[ch];
        for (int i = 0; i < div * 8; i++) begin
            @(negedge clk);
            if (led_out[ch] !== prev) begin
                if (last >= 0 && (i - last) != div) bad++;
                last = i;
                n_tr++;
                prev = led_out[ch];
            end
        end
        chk(req, "bad toggle intervals", bad, 0);
        chk(req, "enough toggles", int'(n_tr >= 6), 1);
    endtask

    // Both LEDs must match on every cycle over a window
    task automatic check_in_phase(input int cycles);
        int mism = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (led_out[0] !== led_out[1]) mism++;
        end
        chk("R8", "phase mismatches", mism, 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "osc_sel", osc_sel, 0);
        chk("R1", "chan_rst", chan_rst, 2'b11);
        chk("R1", "led_out dark", led_out, 2'b00);
        chk("R1", "rdata", bus_rdata, 0);
        bus_read(AW'('h00), rd);
        chk("R1", "ctrl readback", rd, 8'hFC);

        // R2 R3 R4 R5: vector table
        for (int v = 0; v < NV; v++) begin
            bus_write(AW'('h00), VECS[v][13:6]);
            chk("R3", "osc_sel", osc_sel, VECS[v][5:4]);
            chk("R4", "chan_rst", chan_rst, VECS[v][3:2]);
            chk("R5", "led_out", led_out, VECS[v][1:0]);
            bus_read(AW'('h00), rd);
            chk("R2", "readback", rd, VECS[v][13:6]);
        end

        // R9: firmware bytes, writes ignored
        bus_read(AW'('h10), rd);
        chk("R9", "fw major", rd, FWMAJ);
        bus_read(AW'('h12), rd);
        chk("R9", "fw minor", rd, FWMIN);
        bus_write(AW'('h10), 8'h55);
        bus_write(AW'('h12), 8'hAA);
        bus_read(AW'('h10), rd);
        chk("R9", "fw major after write", rd, FWMAJ);
        bus_read(AW'('h12), rd);
        chk("R9", "fw minor after write", rd, FWMIN);

        // R10: status and unmapped reads, writes elsewhere ignored
        bus_read(AW'('h02), rd);
        chk("R10", "status", rd, 0);
        bus_read(AW'('h3F), rd);
        chk("R10", "unmapped 3F", rd, 0);
        bus_read(AW'('h11), rd);
        chk("R10", "unmapped 11", rd, 0);
        bus_write(AW'('h02), 8'h00);
        bus_write(AW'('h01), 8'h00);
        chk("R10", "chan_rst kept", chan_rst, 2'b11);
        chk("R10", "osc_sel kept", osc_sel, 2'd3);
        bus_read(AW'('h00), rd);
        chk("R10", "ctrl kept", rd, 8'hCF);

        // R4: reset held as long as its bit stays set
        bus_write(AW'('h00), 8'h04);
        begin
            int drop = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (chan_rst !== 2'b01) drop++;
            end
            chk("R4", "reset held cycles lost", drop, 0);
        end

        // R6 R8: both fast
        bus_write(AW'('h00), 8'h50);
        measure_blink(0, FDIV, "R6");
        check_in_phase(FDIV * 6);
        // R7 R8: both slow
        bus_write(AW'('h00), 8'hA0);
        measure_blink(1, SDIV, "R7");
        check_in_phase(SDIV * 6);
        // R6 R7: mixed rates
        bus_write(AW'('h00), 8'h90);
        measure_blink(0, FDIV, "R6");
        measure_blink(1, SDIV, "R7");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "osc_sel after reset", osc_sel, 0);
        chk("R1", "chan_rst after reset", chan_rst, 2'b11);
        chk("R1", "led_out after reset", led_out, 2'b00);
        rst_n = 1'b1;
        bus_read(AW'('h00), rd);
        chk("R1", "ctrl after reset", rd, 8'hFC);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule